// File: doc/BRIEF.md
# Dual-Port Serial-Access Video Memory

This block models a 65,536-bit single-bit-wide dynamic memory that can be reached along two paths. The random path behaves like an ordinary multiplexed-address memory. An 8-bit address bus carries the row when the row strobe falls and the column when the column strobe falls. Several column accesses may follow one row opening (page mode). A write whose write enable is already low when the column strobe falls (early write) leaves the data output disabled.

The sequential path is a 256-bit shift register built from four 64-bit segments. A transfer cycle is requested by holding the transfer/output-enable input low when the row strobe falls. It either loads an entire row into the register (write enable high) or stores the register back into a row (write enable low). A tap setting picks a serial length of 64, 128, 192 or 256 shifts, and the high column bits given at load time pick the segment where the stream starts. Serial input and serial output move in the same shift cycle. After a load, the serial output presents the row bits in column order starting at the chosen segment. A bit shifted in reappears at the output exactly one serial length later.

All strobes and enables are active-low inputs sampled on the rising edge of `clk`. A shift happens on every rising edge with `shift_en` high. The random-port control is a state machine with these states:
- ST_IDLE: row closed.
- ST_ROW: row open, waiting for a column.
- ST_READ: column read.
- ST_WRITE: early write.
- ST_XFER: transfer requested, waiting for the column.
- ST_XDONE: transfer performed.

Its transitions are:
- open: IDLE to ROW, or IDLE to XFER when a transfer is requested.
- column fall: ROW to READ or ROW to WRITE.
- page return: READ or WRITE back to ROW when the column strobe rises.
- transfer fire: XFER to XDONE.
- close: any state to IDLE when the row strobe rises.

Top module: `vram_dual_port`

## Requirements
- R1: After reset, `dq_oe` and `sdo_oe` are 0 (with `sdo_en_n` high), the serial register holds all zeros, and the serial position is at bit 0.
- R2: The row address is latched on the first clock with `row_stb_n` low in ST_IDLE. With `wr_n` high, a clock with `col_stb_n` low in ST_ROW reads the bit at (row, `addr_i`), and `dq_o` shows it from the next cycle on.
- R3: With `wr_n` low when the column strobe is sampled low, `dq_i` is written to (row, column), and `dq_oe` stays 0 for that access.
- R4: While `row_stb_n` stays low, raising and lowering `col_stb_n` again performs further column accesses on the same latched row.
- R5: `dq_oe` is 1 only in ST_READ, and only while `xfer_oe_n` is 0.
- R6: `xfer_oe_n` low and `wr_n` high at row opening, followed by a column fall, copies the whole row into the serial register. The serial position is set to column `addr_i[7:6]*64`, and the first `sdo` bit equals that column of the row.
- R7: `xfer_oe_n` low and `wr_n` low at row opening, followed by a column fall, writes the 256-bit serial register into the row. Bit k of the register goes to column k.
- R8: `tap_sel` value t gives a serial length of 64*(t+1). After that many shifts the position returns to the start column, so each bit shifted in appears on `sdo` that many shifts later.
- R9: On a shift, `sdi` is stored at the current position in the same cycle as the position advances, so input and output move together.
- R10: `sdo_oe` equals the inverse of `sdo_en_n`.
- R11: Opening and closing a row with no column strobe (refresh) changes no stored bit.
- R12: `dq_oe` stays 0 throughout a transfer cycle, even with `xfer_oe_n` held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Multiplexed row/column address |
| row_stb_n | input | 1 | Row strobe, active low |
| col_stb_n | input | 1 | Column strobe, active low |
| wr_n | input | 1 | Write enable, active low |
| xfer_oe_n | input | 1 | Transfer request at row opening; data output enable otherwise |
| dq_i | input | 1 | Random-port write data |
| dq_o | output | 1 | Random-port read data |
| dq_oe | output | 1 | Drive enable for dq_o (0 means high impedance) |
| shift_en | input | 1 | Serial shift strobe |
| sdi | input | 1 | Serial data in |
| tap_sel | input | 2 | Serial length select (64*(value+1)) |
| sdo_en_n | input | 1 | Serial output enable, active low |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for sdo |

## Verification
The hardest behaviour to reach is a wrapped short-tap stream carrying data that went through a full round trip. That stream starts in a non-zero segment and returns bits shifted in one serial length earlier. The stimulus first fills the serial register with a known 256-bit pattern, then stores it into a row with a write-back transfer. It next reloads that row with a load transfer whose column selects a middle segment. Finally it shifts well past one length at each tap setting, so the reference model must predict both the original row bits and the freshly shifted-in ones.

// File: rtl/vram_pkg.sv
package vram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_READ,
        ST_WRITE,
        ST_XFER,
        ST_XDONE
    } vram_state_e;

endpackage

// File: rtl/vram_strobe_fsm.sv
module vram_strobe_fsm
    import vram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          row_stb_n,
    input  logic          col_stb_n,
    input  logic          wr_n,
    input  logic          xfer_oe_n,
    output vram_state_e   st,
    output logic [AW-1:0] row_q,
    output logic          bit_wr,
    output logic          bit_rd,
    output logic          row_ld,
    output logic          row_wb,
    output logic          rd_phase
);

    vram_state_e st_nx;
    logic        dir_load_q;

    // state register, row latch and transfer direction
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            row_q      <= '0;
            dir_load_q <= 1'b0;
        end else begin
            st <= st_nx;
            if (st == ST_IDLE && !row_stb_n) begin
                row_q      <= addr_i;
                dir_load_q <= wr_n;
            end
        end
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (!row_stb_n) st_nx = xfer_oe_n ? ST_ROW : ST_XFER;
            end
            ST_ROW: begin
                if (row_stb_n)       st_nx = ST_IDLE;
                else if (!col_stb_n) st_nx = wr_n ? ST_READ : ST_WRITE;
            end
            ST_READ, ST_WRITE: begin
                if (row_stb_n)      st_nx = ST_IDLE;
                else if (col_stb_n) st_nx = ST_ROW;
            end
            ST_XFER: begin
                if (row_stb_n)       st_nx = ST_IDLE;
                else if (!col_stb_n) st_nx = ST_XDONE;
            end
            ST_XDONE: begin
                if (row_stb_n) st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bit_wr   = 1'b0;
        bit_rd   = 1'b0;
        row_ld   = 1'b0;
        row_wb   = 1'b0;
        rd_phase = 1'b0;
        unique case (st)
            ST_ROW: begin
                if (!row_stb_n && !col_stb_n) begin
                    bit_wr = !wr_n;
                    bit_rd = wr_n;
                end
            end
            ST_READ: rd_phase = 1'b1;
            ST_XFER: begin
                if (!row_stb_n && !col_stb_n) begin
                    row_ld = dir_load_q;
                    row_wb = !dir_load_q;
                end
            end
            ST_IDLE, ST_WRITE, ST_XDONE: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/vram_cell_array.sv
module vram_cell_array #(
    parameter int AW = 8,
    localparam int ROW_BITS = 1 << AW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       row_sel,
    input  logic [AW-1:0]       col_sel,
    input  logic                bit_wr,
    input  logic                bit_rd,
    input  logic                bit_d,
    input  logic                row_wr,
    input  logic [ROW_BITS-1:0] row_wr_data,
    output logic [ROW_BITS-1:0] row_rd_data,
    output logic                rd_q
);

    logic [ROW_BITS-1:0] cells [ROW_BITS];

    assign row_rd_data = cells[row_sel];

    always_ff @(posedge clk) begin
        if (row_wr) begin
            cells[row_sel] <= row_wr_data;
        end else if (bit_wr) begin
            cells[row_sel][col_sel] <= bit_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rd_q <= 1'b0;
        else if (bit_rd) rd_q <= cells[row_sel][col_sel];
    end

endmodule

// File: rtl/vram_serial_chain.sv
module vram_serial_chain #(
    parameter int AW    = 8,
    parameter int N_SEG = 4,
    localparam int ROW_BITS = 1 << AW,
    localparam int SEG_W    = $clog2(N_SEG),
    localparam int SEG_LEN  = ROW_BITS / N_SEG,
    localparam int SEG_LOG  = $clog2(SEG_LEN)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic                sdi,
    input  logic [SEG_W-1:0]    tap_sel,
    input  logic                load_en,
    input  logic [ROW_BITS-1:0] load_data,
    input  logic [SEG_W-1:0]    load_seg,
    output logic [ROW_BITS-1:0] chain_q,
    output logic                sdo,
    output logic [AW-1:0]       off_q,
    output logic [AW-1:0]       len_m1
);

    logic [AW-1:0]    base_q;
    logic [AW-1:0]    pos;
    logic [N_SEG-1:0] seg_bit;

    assign len_m1 = {tap_sel, {SEG_LOG{1'b1}}};
    assign pos    = base_q + off_q;

    // one tap per segment, then pick the segment holding the position
    for (genvar g = 0; g < N_SEG; g++) begin : g_seg
        assign seg_bit[g] = chain_q[g*SEG_LEN + int'(pos[SEG_LOG-1:0])];
    end
    assign sdo = seg_bit[pos[AW-1 -: SEG_W]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            base_q  <= '0;
            off_q   <= '0;
        end else if (load_en) begin
            chain_q <= load_data;
            base_q  <= {load_seg, {SEG_LOG{1'b0}}};
            off_q   <= '0;
        end else if (shift_en) begin
            chain_q[pos] <= sdi;
            off_q        <= (off_q >= len_m1) ? '0 : off_q + 1'b1;
        end
    end

endmodule

// File: rtl/vram_dual_port.sv
module vram_dual_port
    import vram_pkg::*;
#(
    parameter int AW    = 8,
    parameter int N_SEG = 4,
    localparam int ROW_BITS = 1 << AW,
    localparam int SEG_W    = $clog2(N_SEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr_i,
    input  logic             row_stb_n,
    input  logic             col_stb_n,
    input  logic             wr_n,
    input  logic             xfer_oe_n,
    input  logic             dq_i,
    output logic             dq_o,
    output logic             dq_oe,
    input  logic             shift_en,
    input  logic             sdi,
    input  logic [SEG_W-1:0] tap_sel,
    input  logic             sdo_en_n,
    output logic             sdo,
    output logic             sdo_oe
);

    vram_state_e         st;
    logic [AW-1:0]       row_q;
    logic                bit_wr;
    logic                bit_rd;
    logic                row_ld;
    logic                row_wb;
    logic                rd_phase;
    logic [ROW_BITS-1:0] row_rd_data;
    logic [ROW_BITS-1:0] chain_q;
    logic [AW-1:0]       off_q;
    logic [AW-1:0]       len_m1;

    vram_strobe_fsm #(.AW(AW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (addr_i),
        .row_stb_n (row_stb_n),
        .col_stb_n (col_stb_n),
        .wr_n      (wr_n),
        .xfer_oe_n (xfer_oe_n),
        .st        (st),
        .row_q     (row_q),
        .bit_wr    (bit_wr),
        .bit_rd    (bit_rd),
        .row_ld    (row_ld),
        .row_wb    (row_wb),
        .rd_phase  (rd_phase)
    );

    vram_cell_array #(.AW(AW)) u_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .row_sel     (row_q),
        .col_sel     (addr_i),
        .bit_wr      (bit_wr),
        .bit_rd      (bit_rd),
        .bit_d       (dq_i),
        .row_wr      (row_wb),
        .row_wr_data (chain_q),
        .row_rd_data (row_rd_data),
        .rd_q        (dq_o)
    );

    vram_serial_chain #(.AW(AW), .N_SEG(N_SEG)) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .sdi       (sdi),
        .tap_sel   (tap_sel),
        .load_en   (row_ld),
        .load_data (row_rd_data),
        .load_seg  (addr_i[AW-1 -: SEG_W]),
        .chain_q   (chain_q),
        .sdo       (sdo),
        .off_q     (off_q),
        .len_m1    (len_m1)
    );

    assign dq_oe  = rd_phase & ~xfer_oe_n;
    assign sdo_oe = ~sdo_en_n;

endmodule

// File: rtl/vram_dual_port_chk.sv
module vram_dual_port_chk
    import vram_pkg::*;
#(
    parameter int AW = 8,
    parameter int SEG_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             row_stb_n,
    input logic             col_stb_n,
    input logic             wr_n,
    input logic             xfer_oe_n,
    input logic             dq_oe,
    input logic             shift_en,
    input logic [SEG_W-1:0] tap_sel,
    input logic             sdo_en_n,
    input logic             sdo_oe,
    input vram_state_e      st,
    input logic [AW-1:0]    row_q,
    input logic             bit_wr,
    input logic             row_ld,
    input logic             row_wb,
    input logic [AW-1:0]    off_q,
    input logic [AW-1:0]    len_m1
);

    p_read_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ROW && !row_stb_n && !col_stb_n && wr_n) |=> (st == ST_READ));

    p_early_write_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WRITE) |-> !dq_oe);

    p_row_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && $past(st) != ST_IDLE) |-> $stable(row_q));

    p_oe_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_oe_n |-> !dq_oe);

    p_load_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        row_ld |=> (st == ST_XDONE));

    p_wb_in_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        row_wb |=> (st == ST_XDONE));

    p_ptr_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(shift_en) && $stable(tap_sel)) |-> (off_q <= len_m1));

    p_sdo_hiz_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_en_n |-> !sdo_oe);

    p_refresh_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_ROW) |-> !bit_wr);

    p_no_dq_in_xfer_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_XFER || st == ST_XDONE) |-> !dq_oe);

endmodule

bind vram_dual_port vram_dual_port_chk #(.AW(AW), .SEG_W(SEG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_stb_n (row_stb_n),
    .col_stb_n (col_stb_n),
    .wr_n      (wr_n),
    .xfer_oe_n (xfer_oe_n),
    .dq_oe     (dq_oe),
    .shift_en  (shift_en),
    .tap_sel   (tap_sel),
    .sdo_en_n  (sdo_en_n),
    .sdo_oe    (sdo_oe),
    .st        (st),
    .row_q     (row_q),
    .bit_wr    (bit_wr),
    .row_ld    (row_ld),
    .row_wb    (row_wb),
    .off_q     (off_q),
    .len_m1    (len_m1)
);

// File: tb/vram_dual_port_bench.sv
`timescale 1ns/1ps
module vram_dual_port_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr_i = '0;
    logic       row_stb_n = 1'b1, col_stb_n = 1'b1, wr_n = 1'b1, xfer_oe_n = 1'b1;
    logic       dq_i = 1'b0, shift_en = 1'b0, sdi = 1'b0, sdo_en_n = 1'b1;
    logic [1:0] tap_sel = 2'd3;
    logic       dq_o, dq_oe, sdo, sdo_oe;

    always #2.5 clk = ~clk;

    vram_dual_port u_vram_dual_port (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .row_stb_n(row_stb_n),
        .col_stb_n(col_stb_n), .wr_n(wr_n), .xfer_oe_n(xfer_oe_n), .dq_i(dq_i),
        .dq_o(dq_o), .dq_oe(dq_oe), .shift_en(shift_en), .sdi(sdi),
        .tap_sel(tap_sel), .sdo_en_n(sdo_en_n), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;
    string cur_req = "R1";

    // behavioural reference
    bit mm [256][256];
    bit mk [256][256];
    bit sh [256];
    bit shk [256];
    int phase, row_m, base_m, off_m;
    bit dir_load_m, rd_v, rd_k;
    bit [31:0] lfsr = 32'h1D2C_3B4A;

    task automatic chk(input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    function automatic bit rnd();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr[0];
    endfunction

    task automatic model_reset();
        phase = 0; row_m = 0; base_m = 0; off_m = 0; rd_k = 0; rd_v = 0;
        for (int i = 0; i < 256; i++) begin sh[i] = 0; shk[i] = 1; end
    endtask

    task automatic model_step();
        bit old [256];
        bit oldk [256];
        int len;
        for (int i = 0; i < 256; i++) begin old[i] = sh[i]; oldk[i] = shk[i]; end
        len = 64 * (int'(tap_sel) + 1);
        if (shift_en) begin
            sh[(base_m + off_m) % 256] = sdi;
            shk[(base_m + off_m) % 256] = 1;
            off_m = (off_m >= len - 1) ? 0 : off_m + 1;
        end
        case (phase)
            0: if (!row_stb_n) begin
                   row_m = addr_i; dir_load_m = wr_n;
                   phase = xfer_oe_n ? 1 : 4;
               end
            1: if (row_stb_n) phase = 0;
               else if (!col_stb_n) begin
                   if (!wr_n) begin
                       mm[row_m][addr_i] = dq_i; mk[row_m][addr_i] = 1; phase = 3;
                   end else begin
                       rd_v = mm[row_m][addr_i]; rd_k = mk[row_m][addr_i]; phase = 2;
                   end
               end
            2, 3: if (row_stb_n) phase = 0; else if (col_stb_n) phase = 1;
            4: if (row_stb_n) phase = 0;
               else if (!col_stb_n) begin
                   if (dir_load_m) begin
                       for (int i = 0; i < 256; i++) begin
                           sh[i] = mm[row_m][i]; shk[i] = mk[row_m][i];
                       end
                       base_m = (int'(addr_i) / 64) * 64; off_m = 0;
                   end else begin
                       for (int i = 0; i < 256; i++) begin
                           mm[row_m][i] = old[i]; mk[row_m][i] = oldk[i];
                       end
                   end
                   phase = 5;
               end
            default: if (row_stb_n) phase = 0;
        endcase
    endtask

    // model advances on each edge; outputs are compared 1 ns later
    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else model_step();
        #1;
        if (rst_n && !done) begin
            bit exp_oe;
            int p;
            exp_oe = (phase == 2) && !xfer_oe_n;
            chk("dq_oe", dq_oe, exp_oe);
            if (exp_oe && rd_k) chk("dq_o", dq_o, rd_v);
            chk("sdo_oe", sdo_oe, !sdo_en_n);
            p = (base_m + off_m) % 256;
            if (shk[p]) chk("sdo", sdo, sh[p]);
        end
    end

    task automatic cyc(); @(negedge clk); endtask

    task automatic ras_open(input int row, input bit trg, input bit we);
        addr_i = 8'(row); row_stb_n = 0; xfer_oe_n = trg; wr_n = we; cyc();
    endtask

    task automatic ras_close();
        row_stb_n = 1; col_stb_n = 1; wr_n = 1; xfer_oe_n = 1; cyc();
    endtask

    task automatic col_acc(input int col, input bit we, input bit d, input bit oe_n,
                           input bit chk_rd, input bit exp_d);
        addr_i = 8'(col); wr_n = we; dq_i = d; xfer_oe_n = oe_n; col_stb_n = 0; cyc();
        if (chk_rd) chk("read data", dq_o, exp_d);
        if (!we) chk("early write dq_oe", dq_oe, 0);
        cyc(); col_stb_n = 1; cyc();
    endtask

    task automatic transfer(input int row, input bit load, input int col);
        ras_open(row, 0, load);
        addr_i = 8'(col); col_stb_n = 0; cyc();
        chk("dq_oe in transfer", dq_oe, 0);
        col_stb_n = 1; cyc();
        ras_close();
    endtask

    task automatic shifts(input int n, input bit rnd_in);
        shift_en = 1;
        for (int i = 0; i < n; i++) begin sdi = rnd_in ? rnd() : 1'b0; cyc(); end
        shift_en = 0; cyc();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bit pat [256];
        repeat (3) cyc();
        cur_req = "R1";
        chk("reset dq_oe", dq_oe, 0);
        chk("reset sdo_oe", sdo_oe, 0);
        chk("reset sdo", sdo, 0);
        rst_n = 1; cyc();
        chk("post-reset sdo", sdo, 0);

        // R3 early writes, R4 page mode on one row
        cur_req = "R3";
        ras_open(8'h12, 1, 1);
        col_acc(3, 0, 1, 1, 0, 0);
        col_acc(200, 0, 0, 1, 0, 0);
        col_acc(77, 0, 1, 1, 0, 0);
        ras_close();
        cur_req = "R4";
        ras_open(8'h12, 1, 1);
        col_acc(3, 1, 0, 0, 1, 1);
        col_acc(200, 1, 0, 0, 1, 0);
        col_acc(77, 1, 0, 0, 1, 1);
        cur_req = "R5";
        addr_i = 8'd3; wr_n = 1; xfer_oe_n = 1; col_stb_n = 0; cyc();
        chk("dq_oe with xfer_oe_n high", dq_oe, 0);
        xfer_oe_n = 0; #1;
        chk("dq_oe after xfer_oe_n low", dq_oe, 1);
        cyc(); col_stb_n = 1; cyc();
        ras_close();
        cur_req = "R2";
        ras_open(8'h13, 1, 1);
        col_acc(3, 0, 0, 1, 0, 0);
        ras_close();
        ras_open(8'h12, 1, 1);
        col_acc(3, 1, 0, 0, 1, 1);
        ras_close();

        // R9/R10: fill the serial register with a pattern
        cur_req = "R9";
        sdo_en_n = 0; tap_sel = 2'd3;
        shift_en = 1;
        for (int i = 0; i < 256; i++) begin
            pat[i] = rnd(); sdi = pat[i]; cyc();
        end
        shift_en = 0; cyc();
        cur_req = "R10";
        sdo_en_n = 1; cyc(); chk("sdo_oe disabled", sdo_oe, 0);
        sdo_en_n = 0; cyc(); chk("sdo_oe enabled", sdo_oe, 1);

        // R7 write-back, then read bits back on the random port
        cur_req = "R7";
        transfer(8'h40, 0, 0);
        ras_open(8'h40, 1, 1);
        col_acc(0, 1, 0, 0, 1, pat[0]);
        col_acc(129, 1, 0, 0, 1, pat[129]);
        col_acc(255, 1, 0, 0, 1, pat[255]);
        ras_close();

        // R11 refresh-only cycle
        cur_req = "R11";
        ras_open(8'h40, 1, 1); cyc(); ras_close();
        ras_open(8'h40, 1, 1);
        col_acc(129, 1, 0, 0, 1, pat[129]);
        col_acc(64, 1, 0, 0, 1, pat[64]);
        ras_close();

        // R6/R12 load transfer starting at segment 2, full length
        cur_req = "R12";
        shifts(40, 1);
        cur_req = "R6";
        transfer(8'h40, 1, 8'h80);
        chk("first serial bit", sdo, pat[128]);
        shifts(256, 0);

        // R8 short taps from various segments
        cur_req = "R8";
        for (int t = 0; t < 3; t++) begin
            tap_sel = 2'(t);
            transfer(8'h40, 1, 64 * (t + 1) - 1);
            chk("start bit", sdo, pat[64 * t]);
            shifts(64 * (t + 1) + 50, 1);
        end
        tap_sel = 2'd0;
        transfer(8'h40, 1, 8'hC0);
        shifts(64, 0);
        chk("wrap to start after 64", sdo, 0);
        tap_sel = 2'd3;

        repeat (4) cyc();
        finish_run();
    end

endmodule